// File: doc/BRIEF.md
# Two-Channel Interrupt Cause and Mask Unit

This unit records events from two engine channels in one 32-bit cause register and gates them with a 32-bit mask register of the same layout. Each channel owns a 16-bit field, and channel n's field starts at bit n*16. The unit drives one interrupt line per channel.

Each channel pulses single-cycle event inputs: end of chain, end of descriptor and six error kinds. A pulse sets a sticky bit in the channel's field. Software reads the cause register through a simple register port. It clears bits by writing zeros; a one leaves the bit alone. A single write of a word with one zero clears exactly one event, for example one channel's end-of-chain bit, without disturbing any other bit.

The register port is combinational on read. Writes take effect at the rising clock edge.

Top module: `irq_cause_mask`

## Requirements
- R1: After reset, the cause register (address 0) and the mask register (address 1) read 0, and both interrupt outputs are low.
- R2: A one-cycle pulse on a channel's event input sets a bit in that channel's field (bit n*16+k): end of chain at k=0, end of descriptor at k=1, error kind j (0..5) at k=4+j. The bit reads back as set from the cycle after the pulse and stays set until it is cleared.
- R3: A write to address 0 clears every implemented cause bit whose write-data bit is 0 and leaves every bit whose write-data bit is 1 unchanged, in both channel fields.
- R4: If an event and a clearing write hit the same cause bit in the same cycle, the bit is set after that edge.
- R5: A write to address 1 loads the mask. Only the bit positions 0, 1 and 4..9 of each field are implemented; the other positions (2, 3, 10..15) read 0 in both registers whatever is written or signalled.
- R6: irq_o[n] is high exactly when the AND of channel n's cause field and mask field is non-zero. It follows register changes from the cycle after the causing edge.
- R7: Writes to addresses 2 and 3 change no register, and reads from them return 0.
- R8: The mask register changes only on a write to address 1. Events are recorded in the cause register whether or not they are masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| eoc_i | input | 2 | Per-channel end-of-chain event pulse |
| eod_i | input | 2 | Per-channel end-of-descriptor event pulse |
| err_i | input | 12 | Per-channel error pulses, 6 per channel, channel n at [n*6 +: 6] |
| addr_i | input | 2 | Register address: 0 cause, 1 mask |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 2 | Per-channel interrupt line |

## Verification
A wrong bit in the cause or mask state shows up in two places. It appears on rdata_o in the same cycle the register is addressed. It changes the affected irq_o line in the cycle after the bad edge whenever the matching bit of the other register is set. The bench therefore compares both outputs against a reference model on every cycle, before the next edge. Random traffic mixes events with clearing writes so that collisions, masked-off events and single-bit clears each reach the ports within one cycle of happening.

// File: rtl/irqcm_pkg.sv
package irqcm_pkg;
  localparam int unsigned CAUSE_ADDR = 0;
  localparam int unsigned MASK_ADDR  = 1;
  localparam int unsigned EOC_POS    = 0;
  localparam int unsigned EOD_POS    = 1;

  // implemented bit positions inside one channel field
  function automatic logic [31:0] impl_bits(input int unsigned err_lsb, input int unsigned err_w);
    logic [31:0] m;
    m = '0;
    m[EOC_POS] = 1'b1;
    m[EOD_POS] = 1'b1;
    for (int unsigned i = 0; i < err_w; i++) m[err_lsb + i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqcm_event_map.sv
module irqcm_event_map #(
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned ERR_W   = 6,
  parameter int unsigned ERR_LSB = 4
) (
  input  logic               eoc_i,
  input  logic               eod_i,
  input  logic [ERR_W-1:0]   err_i,
  output logic [FIELD_W-1:0] set_o
);
  import irqcm_pkg::*;

  always_comb begin
    set_o = '0;
    set_o[EOC_POS] = eoc_i;
    set_o[EOD_POS] = eod_i;
    for (int unsigned j = 0; j < ERR_W; j++) set_o[ERR_LSB + j] = err_i[j];
  end
endmodule

// File: rtl/irqcm_cause_field.sv
module irqcm_cause_field #(
  parameter int unsigned       FIELD_W = 16,
  parameter logic [FIELD_W-1:0] IMPL   = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] set_i,
  input  logic               wr_i,
  input  logic [FIELD_W-1:0] wdata_i,
  output logic [FIELD_W-1:0] cause_o
);
  logic [FIELD_W-1:0] clr;
  logic [FIELD_W-1:0] cause_q;

  // zero in write data clears, one keeps
  assign clr = wr_i ? ~wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= ((cause_q & ~clr) | set_i) & IMPL;
  end

  assign cause_o = cause_q;

  // R4
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & IMPL)) |=> ((cause_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_o & ~$past(cause_o)) & ~$past(set_i)) == '0);

  // R3
  clear_on_zero_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~cause_o & $past(cause_o)) & ~$past(clr)) == '0);
endmodule

// File: rtl/irqcm_mask_field.sv
module irqcm_mask_field #(
  parameter int unsigned       FIELD_W = 16,
  parameter logic [FIELD_W-1:0] IMPL   = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [FIELD_W-1:0] wdata_i,
  output logic [FIELD_W-1:0] mask_o
);
  logic [FIELD_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i & IMPL;
  end

  assign mask_o = mask_q;

  // R8
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_cause_mask.sv
module irq_cause_mask #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned ERR_W   = 6,
  parameter int unsigned ERR_LSB = 4,
  parameter int unsigned ADDR_W  = 2,
  localparam int unsigned DATA_W = NUM_CH * FIELD_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       eoc_i,
  input  logic [NUM_CH-1:0]       eod_i,
  input  logic [NUM_CH*ERR_W-1:0] err_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    we_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [NUM_CH-1:0]       irq_o
);
  import irqcm_pkg::*;

  localparam logic [31:0]        IMPL32 = impl_bits(ERR_LSB, ERR_W);
  localparam logic [FIELD_W-1:0] IMPL   = IMPL32[FIELD_W-1:0];

  logic              sel_cause;
  logic              sel_mask;
  logic [DATA_W-1:0] cause_all;
  logic [DATA_W-1:0] mask_all;

  assign sel_cause = (addr_i == ADDR_W'(CAUSE_ADDR));
  assign sel_mask  = (addr_i == ADDR_W'(MASK_ADDR));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [FIELD_W-1:0] set_v;

    irqcm_event_map #(.FIELD_W(FIELD_W), .ERR_W(ERR_W), .ERR_LSB(ERR_LSB)) u_map (
      .eoc_i (eoc_i[g]),
      .eod_i (eod_i[g]),
      .err_i (err_i[g*ERR_W +: ERR_W]),
      .set_o (set_v)
    );

    irqcm_cause_field #(.FIELD_W(FIELD_W), .IMPL(IMPL)) u_cause (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_v),
      .wr_i    (we_i & sel_cause),
      .wdata_i (wdata_i[g*FIELD_W +: FIELD_W]),
      .cause_o (cause_all[g*FIELD_W +: FIELD_W])
    );

    irqcm_mask_field #(.FIELD_W(FIELD_W), .IMPL(IMPL)) u_mask (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (we_i & sel_mask),
      .wdata_i (wdata_i[g*FIELD_W +: FIELD_W]),
      .mask_o  (mask_all[g*FIELD_W +: FIELD_W])
    );

    assign irq_o[g] = |(cause_all[g*FIELD_W +: FIELD_W] & mask_all[g*FIELD_W +: FIELD_W]);

    // R6
    irq_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[g]) |-> (!$stable(cause_all[g*FIELD_W +: FIELD_W]) ||
                           !$stable(mask_all[g*FIELD_W +: FIELD_W])));
  end

  always_comb begin
    if (sel_cause)     rdata_o = cause_all;
    else if (sel_mask) rdata_o = mask_all;
    else               rdata_o = '0;
  end
endmodule

// File: tb/sim_irq_cause_mask.sv
`timescale 1ns/1ps
module sim_irq_cause_mask;
  localparam logic [31:0] IMPLW = 32'h03F3_03F3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  eoc = '0, eod = '0;
  logic [11:0] err = '0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [31:0] m_cause = '0, m_mask = '0;

  always #2.5 clk = ~clk;

  irq_cause_mask u0 (
    .clk_i(clk), .rst_ni(rst_n), .eoc_i(eoc), .eod_i(eod), .err_i(err),
    .addr_i(addr), .wdata_i(wdata), .we_i(we), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] evt_word(input logic [1:0] c, input logic [1:0] d, input logic [11:0] e);
    logic [31:0] w = '0;
    for (int n = 0; n < 2; n++) begin
      w[n*16] = c[n];
      w[n*16+1] = d[n];
      for (int j = 0; j < 6; j++) w[n*16+4+j] = e[n*6+j];
    end
    return w;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    return (a == 2'd0) ? m_cause : (a == 2'd1) ? m_mask : 32'h0;
  endfunction

  function automatic logic [1:0] exp_irq();
    logic [1:0] r;
    for (int n = 0; n < 2; n++) r[n] = |(m_cause[n*16 +: 16] & m_mask[n*16 +: 16]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // drive at negedge, check before next edge, then advance model
  task automatic step(input logic [1:0] c, input logic [1:0] d, input logic [11:0] e,
                      input logic [1:0] a, input logic [31:0] wd, input logic w, input string tag);
    logic [31:0] ev;
    @(negedge clk);
    eoc = c; eod = d; err = e; addr = a; wdata = wd; we = w;
    #1;
    check(tag, rdata, exp_rd(a));
    check("R6 irq", {30'h0, irq}, {30'h0, exp_irq()});
    @(posedge clk);
    ev = evt_word(c, d, e);
    if (w && a == 2'd0) m_cause = ((m_cause & wd) | ev) & IMPLW;
    else                m_cause = (m_cause | ev) & IMPLW;
    if (w && a == 2'd1) m_mask = wd & IMPLW;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(2'b0, 2'b0, 12'h0, a, 32'h0, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, "R1 cause");
    rd(2'd1, "R1 mask");
    // R2 single events in each bit class
    step(2'b01, 2'b00, 12'h0, 2'd0, 32'h0, 1'b0, "R2 idle");
    rd(2'd0, "R2 eoc ch0 -> 0x1");
    step(2'b00, 2'b10, 12'b100000_000001, 2'd1, 32'h0, 1'b0, "R2 mask");
    rd(2'd0, "R2 eod ch1, err ch0 k0, err ch1 k5");
    // R5 mask write with all ones, reserved bits read 0
    step(2'b0, 2'b0, 12'h0, 2'd1, 32'hFFFF_FFFF, 1'b1, "R5 pre");
    rd(2'd1, "R5 mask readback 03F303F3");
    rd(2'd0, "R6 irq both high");
    // R3 clear only ch0 end-of-chain
    step(2'b0, 2'b0, 12'h0, 2'd0, 32'hFFFF_FFFE, 1'b1, "R3 pre");
    rd(2'd0, "R3 single bit clear");
    step(2'b0, 2'b0, 12'h0, 2'd0, 32'hFFFF_FFFF, 1'b1, "R3 ones");
    rd(2'd0, "R3 write ones keeps");
    // R4 collision on ch1 eod bit 17
    step(2'b0, 2'b10, 12'h0, 2'd0, 32'hFFFD_FFFF, 1'b1, "R4 pre");
    rd(2'd0, "R4 event wins");
    // clear ch0 errors with FFFF0000 pattern
    step(2'b0, 2'b0, 12'h0, 2'd0, 32'hFFFF_0000, 1'b1, "R3 pre2");
    rd(2'd0, "R3 ch0 field clear");
    // R7 unused addresses
    step(2'b0, 2'b0, 12'h0, 2'd2, 32'h0, 1'b1, "R7 rd2");
    step(2'b0, 2'b0, 12'h0, 2'd3, 32'h0, 1'b1, "R7 rd3");
    rd(2'd0, "R7 cause unchanged");
    rd(2'd1, "R7 mask unchanged");
    // R8 masked events still recorded
    step(2'b0, 2'b0, 12'h0, 2'd1, 32'h0, 1'b1, "R8 pre");
    step(2'b11, 2'b11, 12'hFFF, 2'd0, 32'h0, 1'b0, "R8 ev");
    rd(2'd0, "R8 masked recorded");
    rd(2'd1, "R8 mask stays 0");
    // R3 clear all
    step(2'b0, 2'b0, 12'h0, 2'd0, 32'h0, 1'b1, "R3 pre3");
    rd(2'd0, "R3 all cleared");
    // random traffic, fixed seed
    void'($urandom(32'h1CE5));
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  c, d, a;
      logic [11:0] e;
      logic [31:0] wd;
      logic        w;
      c  = (($urandom % 4) == 0) ? 2'($urandom) : 2'b0;
      d  = (($urandom % 4) == 0) ? 2'($urandom) : 2'b0;
      e  = (($urandom % 6) == 0) ? 12'($urandom) & 12'($urandom) : 12'h0;
      a  = 2'($urandom);
      w  = (($urandom % 5) == 0);
      wd = (($urandom % 2) == 0) ? ~(32'h1 << ($urandom % 32)) : $urandom;
      step(c, d, e, a, wd, w, "R3 random readback");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule